// File: doc/BRIEF.md
# Programmable Duty-Cycle Delay Calculator

This block sits behind the period measurement of a pulse-width controlled clock generator. It takes the result of the measurement, a coarse thermometer code and a fine thermometer code, and turns it into a binary period code. It then forms a target delay: a fraction of that period, chosen by a 4-bit user mask, built only from right-shifted copies of the period code and a short adder chain. No table is involved. The 1/8 and 1/16 terms share one adder input.

The target delay is held in a register. It decides when the generated clock falls. A counter models the output flip-flop. The one-shot pulse sets it, and it clears when the target delay has run out. The high time of the output is therefore a programmable fraction of the measured period.

Top module: `dcd_duty_delay`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `delay_code` is 0, `delay_valid` is 0 and `gen_clk` is 0.
- R2: The coarse index is the number of ones in `coarse_therm` (0 to 15). The fine count is the number of ones in `fine_therm` (0 to 3). The period code is 4 × coarse index + fine count, and it saturates at 63.
- R3: The target delay is the sum of floor(period / 2) when mask bit 0 is set, floor(period / 4) when bit 1 is set, floor(period / 8) when bit 2 is set, and floor(period / 16) when bit 3 is set.
- R4: When mask bits 2 and 3 are both set, only the 1/8 term is added and the 1/16 term is dropped, because the two terms share one adder input.
- R5: `delay_code` takes the new target on the clock edge that samples `fine_done` high. `delay_valid` is high for exactly the cycle that follows such an edge. At all other times `delay_code` keeps its value, whatever the measurement and mask inputs do.
- R6: If `oneshot` is sampled high while `delay_code` is nonzero, `gen_clk` rises on that edge and stays high for exactly `delay_code` cycles.
- R7: If `oneshot` is sampled high while `delay_code` is zero, the pulse is ignored and `gen_clk` stays low. A zero mask or a very short period produces this case.
- R8: If `oneshot` is sampled on the same edge on which the running pulse would end, the set wins. `gen_clk` stays high for a fresh full target length.
- R9: The length of a running pulse is latched when the pulse starts. A new result that lands during the pulse does not change that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_therm | input | 15 | Coarse detection result, thermometer coded |
| fine_therm | input | 3 | Fine detection result, thermometer coded |
| fine_done | input | 1 | Strobe: measurement complete, latch a new target |
| duty_mask | input | 4 | Term select: bit0 1/2, bit1 1/4, bit2 1/8, bit3 1/16 |
| oneshot | input | 1 | Rising-edge pulse for the generated clock |
| delay_code | output | 6 | Registered target delay code |
| delay_valid | output | 1 | One-cycle strobe when a new target is available |
| gen_clk | output | 1 | Modelled output flip-flop |

## Verification
Two events can fall on the same edge. One is the end of a running high phase. The other is a new `oneshot` set, which must win and reload a full count. The bench first measures how many cycles the pulse stays high. It then fires `oneshot` on the last high cycle and expects an unbroken high time of exactly twice the target. A second coincidence delivers a new `fine_done` result in the middle of a pulse. The bench checks that the pulse length does not change and that only the next pulse uses the new code.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // Period code: coarse steps weighted by fine steps per coarse step, plus fine
  // steps, clipped to the largest code the width can hold.
  function automatic int period_of(int coarse_ones, int fine_ones,
                                   int fine_per_coarse, int max_code);
    int p;
    p = coarse_ones * fine_per_coarse + fine_ones;
    if (p > max_code) p = max_code;
    return p;
  endfunction

  // Number of right shifts applied for mask bit k (bit 0 halves the period).
  function automatic int shift_of(int k);
    return k + 1;
  endfunction

endpackage

// File: rtl/dcd_period_enc.sv
module dcd_period_enc #(
  parameter int COARSE_CELLS    = 15,
  parameter int FINE_CELLS      = 3,
  parameter int FINE_PER_COARSE = 4,
  parameter int CODE_W          = 6
) (
  input  logic [COARSE_CELLS-1:0] coarse_therm,
  input  logic [FINE_CELLS-1:0]   fine_therm,
  output logic [CODE_W-1:0]       period_code
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  int coarse_ones;
  int fine_ones;

  always_comb begin
    coarse_ones = $countones(coarse_therm);
    fine_ones   = $countones(fine_therm);
    period_code = CODE_W'(dcd_pkg::period_of(coarse_ones, fine_ones,
                                             FINE_PER_COARSE, MAX_CODE));
  end
endmodule

// File: rtl/dcd_scaler.sv
module dcd_scaler #(
  parameter int CODE_W = 6,
  parameter int MASK_W = 4
) (
  input  logic [CODE_W-1:0] period_code,
  input  logic [MASK_W-1:0] duty_mask,
  output logic [CODE_W-1:0] target_code
);
  localparam int SUM_W    = CODE_W + 1;
  localparam int PLAIN_N  = MASK_W - 2;   // terms with a dedicated adder
  localparam int SHR_A    = dcd_pkg::shift_of(MASK_W - 2);
  localparam int SHR_B    = dcd_pkg::shift_of(MASK_W - 1);

  logic [CODE_W-1:0] shared_term;
  logic [SUM_W-1:0]  psum [PLAIN_N+1];

  // The two finest terms share one adder input; the coarser one wins.
  always_comb begin
    if (duty_mask[MASK_W-2])      shared_term = period_code >> SHR_A;
    else if (duty_mask[MASK_W-1]) shared_term = period_code >> SHR_B;
    else                          shared_term = '0;
  end

  assign psum[0] = {1'b0, shared_term};

  for (genvar k = 0; k < PLAIN_N; k++) begin : g_term
    logic [CODE_W-1:0] term;
    assign term       = duty_mask[k] ? (period_code >> dcd_pkg::shift_of(k)) : '0;
    assign psum[k+1]  = psum[k] + {1'b0, term};
  end

  // The sum of the scaled terms is always below the period, so it fits.
  assign target_code = psum[PLAIN_N][CODE_W-1:0];
endmodule

// File: rtl/dcd_pulse_gen.sv
module dcd_pulse_gen #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] length,
  output logic              pulse_out,
  output logic              expire
);
  logic [CODE_W-1:0] remain;
  logic              start;

  assign start  = fire && (length != '0);
  assign expire = pulse_out && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_out <= 1'b0;
      remain    <= '0;
    end else if (start) begin
      pulse_out <= 1'b1;
      remain    <= length - 1'b1;
    end else if (expire) begin
      pulse_out <= 1'b0;
    end else if (pulse_out) begin
      remain    <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dcd_duty_delay.sv
module dcd_duty_delay #(
  parameter int COARSE_CELLS    = 15,
  parameter int FINE_CELLS      = 3,
  parameter int FINE_PER_COARSE = 4,
  parameter int CODE_W          = 6,
  parameter int MASK_W          = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [COARSE_CELLS-1:0] coarse_therm,
  input  logic [FINE_CELLS-1:0]   fine_therm,
  input  logic                    fine_done,
  input  logic [MASK_W-1:0]       duty_mask,
  input  logic                    oneshot,
  output logic [CODE_W-1:0]       delay_code,
  output logic                    delay_valid,
  output logic                    gen_clk
);
  logic [CODE_W-1:0] period_code;
  logic [CODE_W-1:0] target_next;
  logic              pulse_expire;

  dcd_period_enc #(
    .COARSE_CELLS(COARSE_CELLS), .FINE_CELLS(FINE_CELLS),
    .FINE_PER_COARSE(FINE_PER_COARSE), .CODE_W(CODE_W)
  ) u_enc (
    .coarse_therm(coarse_therm), .fine_therm(fine_therm),
    .period_code(period_code)
  );

  dcd_scaler #(.CODE_W(CODE_W), .MASK_W(MASK_W)) u_scale (
    .period_code(period_code), .duty_mask(duty_mask),
    .target_code(target_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_code  <= '0;
      delay_valid <= 1'b0;
    end else begin
      delay_valid <= fine_done;
      if (fine_done) delay_code <= target_next;
    end
  end

  dcd_pulse_gen #(.CODE_W(CODE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(oneshot), .length(delay_code),
    .pulse_out(gen_clk), .expire(pulse_expire)
  );
endmodule

// File: rtl/dcd_duty_delay_chk.sv
module dcd_duty_delay_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fine_done,
  input logic              oneshot,
  input logic [CODE_W-1:0] period_code,
  input logic [CODE_W-1:0] delay_code,
  input logic              delay_valid,
  input logic              gen_clk,
  input logic              pulse_expire
);
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fine_done |=> delay_valid);
  a_r5_valid_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_done |=> !delay_valid);
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_done |=> $stable(delay_code));
  a_r3_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    fine_done |=> (delay_code <= $past(period_code)));
  a_r6_rise_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && delay_code != '0) |=> gen_clk);
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_clk) |-> $past(oneshot));
  a_r7_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && delay_code == '0 && !gen_clk) |=> !gen_clk);
  a_r8_expire_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_expire && !oneshot) |=> !gen_clk);
  a_r6_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_clk && !pulse_expire) |=> gen_clk);
endmodule

bind dcd_duty_delay dcd_duty_delay_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fine_done(fine_done), .oneshot(oneshot),
  .period_code(period_code), .delay_code(delay_code),
  .delay_valid(delay_valid), .gen_clk(gen_clk), .pulse_expire(pulse_expire)
);

// File: tb/test_dcd_duty_delay.sv
module test_dcd_duty_delay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] coarse_therm;
  logic [2:0]  fine_therm;
  logic        fine_done;
  logic [3:0]  duty_mask;
  logic        oneshot;
  logic [5:0]  delay_code;
  logic        delay_valid;
  logic        gen_clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dcd_duty_delay i_dcd_duty_delay (
    .clk(clk), .rst_n(rst_n), .coarse_therm(coarse_therm),
    .fine_therm(fine_therm), .fine_done(fine_done), .duty_mask(duty_mask),
    .oneshot(oneshot), .delay_code(delay_code), .delay_valid(delay_valid),
    .gen_clk(gen_clk)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(int c, int f);
    int p = 4 * c + f;
    return (p > 63) ? 63 : p;
  endfunction

  function automatic int exp_target(int p, int m);
    int s = 0;
    if (m[0]) s += p / 2;
    if (m[1]) s += p / 4;
    if (m[2]) s += p / 8;
    else if (m[3]) s += p / 16;
    return s;
  endfunction

  function automatic logic [14:0] therm15(int n);
    logic [14:0] t = '0;
    for (int i = 0; i < n; i++) t[i] = 1'b1;
    return t;
  endfunction

  // Load a measurement and latch it; returns at the negedge after the latch.
  task automatic load(int c, int f, int m);
    @(negedge clk);
    coarse_therm = therm15(c);
    fine_therm   = 3'((1 << f) - 1);
    duty_mask    = 4'(m);
    fine_done    = 1'b1;
    @(negedge clk);
    fine_done    = 1'b0;
  endtask

  // Fire oneshot and count high cycles sampled at negedges.
  task automatic measure(output int n);
    @(negedge clk);
    oneshot = 1'b1;
    @(negedge clk);
    oneshot = 1'b0;
    n = 0;
    while (gen_clk && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int t;
    int hi;
    rst_n = 1'b0; coarse_therm = '0; fine_therm = '0;
    fine_done = 1'b0; duty_mask = '0; oneshot = 1'b0;
    repeat (2) @(negedge clk);
    check(delay_code == 0 && !delay_valid && !gen_clk, "R1 in reset",
          int'(delay_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(delay_code == 0 && !delay_valid && !gen_clk, "R1 after release",
          int'(delay_code), 0);

    // R2, R3, R4, R5: full sweep of coarse, fine and mask
    for (int c = 0; c <= 15; c++)
      for (int f = 0; f <= 3; f++)
        for (int m = 0; m < 16; m++) begin
          load(c, f, m);
          t = exp_target(exp_period(c, f), m);
          check(delay_valid == 1'b1, "R5 valid strobe", int'(delay_valid), 1);
          if (m == 12 || m == 13 || m == 14 || m == 15)
            check(int'(delay_code) == t, "R4 shared term", int'(delay_code), t);
          else if (m == 0)
            check(int'(delay_code) == t, "R2 period code", int'(delay_code), t);
          else
            check(int'(delay_code) == t, "R3 target sum", int'(delay_code), t);
        end
    @(negedge clk);
    check(delay_valid == 1'b0, "R5 valid one cycle", int'(delay_valid), 0);

    // R5: inputs move without fine_done, code holds
    t = int'(delay_code);
    coarse_therm = therm15(3); fine_therm = 3'b001; duty_mask = 4'b0001;
    repeat (3) @(negedge clk);
    check(int'(delay_code) == t, "R5 hold", int'(delay_code), t);

    // R6, R7: pulse lengths for several periods and masks
    for (int i = 0; i < 3; i++)
      for (int m = 0; m < 16; m++) begin
        int c = (i == 0) ? 15 : (i == 1) ? 5 : 0;
        int f = (i == 0) ? 3 : (i == 1) ? 2 : 1;
        load(c, f, m);
        t = exp_target(exp_period(c, f), m);
        measure(n);
        if (t == 0) check(n == 0, "R7 zero target ignored", n, 0);
        else        check(n == t, "R6 pulse length", n, t);
        @(negedge clk);
      end

    // R8: fire again on the last high cycle; set beats expiry
    load(10, 1, 4'b0001);
    t = exp_target(exp_period(10, 1), 1);
    @(negedge clk);
    oneshot = 1'b1;
    @(negedge clk);
    oneshot = 1'b0;
    hi = 0;
    while (gen_clk && hi < 200) begin
      hi++;
      if (hi == t) oneshot = 1'b1;
      @(negedge clk);
      oneshot = 1'b0;
    end
    check(hi == 2 * t, "R8 retrigger on expiry", hi, 2 * t);

    // R9: new result mid-pulse leaves running length unchanged
    load(15, 3, 4'b0001);
    t = exp_target(63, 1);
    @(negedge clk);
    oneshot = 1'b1;
    @(negedge clk);
    oneshot = 1'b0;
    coarse_therm = therm15(2); fine_therm = 3'b000; duty_mask = 4'b0001;
    fine_done = 1'b1;
    @(negedge clk);
    fine_done = 1'b0;
    hi = 1;
    while (gen_clk && hi < 200) begin
      hi++;
      @(negedge clk);
    end
    check(hi == t, "R9 latched length", hi, t);
    measure(n);
    check(n == exp_target(8, 1), "R9 next pulse new code", n, exp_target(8, 1));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule